// File: doc/BRIEF.md
# VGA Memory Address Translator

This block turns the 16-bit offset of a legacy VGA processor access into a longword address inside a 4 MB linear graphics memory. Graphics memory holds one longword for each 32-bit group of four plane bytes, so it has 2^20 longword locations. The translated address is a 6-bit base, placed on longword address bits 19:14, plus a plane offset. The block derives that plane offset from the processor offset under the active addressing mode. This lets the VGA window start on any 64 KB boundary of graphics memory.

The mode controls come in as plain level inputs:
- quad-plane (Chain 4) addressing, with an optional packed form;
- odd/even page substitution;
- separate pair-plane (Chain 2) enables for reads and for writes;
- a control that forces offset bit 15 low.

All offset manipulation happens before the base is added. Besides the address, the block reports the addressing mode it applied and a hint saying which planes the access touches. Plane data paths use that hint.

The base sits in a 32-bit configuration word. Software writes the base through one field of that word and reads it back through another field. Each accepted request produces a result one clock later through a single output register stage.

Top module: `vga_addr_xlat`

## Requirements
- R1: The base is written from `cfg_wr_data[5:0]` when `cfg_wr_en` is high, and is 0 after reset. `cfg_rd_data` shows the base in bits 13:8 and reads 0 in every other bit. All other write-data bits are ignored. A request that arrives in the same cycle as a base write still uses the old base.
- R2: A request presented with `req_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high. When `req_valid` is low at an edge, `out_valid` is low after that edge. Reset clears `out_valid`.
- R3: `out_addr` = (base × 2^14 + plane offset) mod 2^20, so a large base plus offset wraps around within the 4 MB memory.
- R4: In planar mode (quad-plane off, pair-plane off for the access direction), `out_mode` is 0 and `out_planes` is 4'b1111. With odd/even also off, the plane offset equals `req_offset`.
- R5: With `mode_chain4` set and `mode_packed` clear, `out_mode` is 2. `out_planes` is one-hot, with bit n set for n = `req_offset[1:0]`. The plane offset is `req_offset` with bits 1:0 cleared.
- R6: With both `mode_chain4` and `mode_packed` set, the plane offset is `req_offset` shifted right by 2.
- R7: `mode_packed` has no effect on any output while `mode_chain4` is clear.
- R8: With `mode_odd_even` set and `mode_chain4` clear, `mode_page_bit` replaces bit 0 of the plane offset.
- R9: Pair-plane mode applies when `mode_chain4` is clear and the enable for the access direction is set: `mode_wr_chain2` when `req_write` is 1, `mode_rd_chain2` when it is 0. In this mode `out_mode` is 1. `out_planes` is 4'b0101 when the original `req_offset[0]` is 0 and 4'b1010 when it is 1. Quad-plane mode takes precedence over pair-plane mode.
- R10: With `mode_force_a15` set, bit 15 of the plane offset is 0. This is applied after packing and page substitution.
- R11: Quad-plane addressing behaves the same for reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the base configuration word |
| cfg_wr_data | input | 32 | Configuration write data; base taken from bits 5:0 |
| cfg_rd_data | output | 32 | Configuration readback; base in bits 13:8 |
| req_valid | input | 1 | Processor access present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_offset | input | 16 | Processor VGA window offset |
| mode_chain4 | input | 1 | Quad-plane addressing |
| mode_packed | input | 1 | Packed form of quad-plane addressing |
| mode_odd_even | input | 1 | Substitute the page bit for offset bit 0 |
| mode_page_bit | input | 1 | Page bit value |
| mode_force_a15 | input | 1 | Force plane offset bit 15 to 0 |
| mode_wr_chain2 | input | 1 | Pair-plane mode for writes |
| mode_rd_chain2 | input | 1 | Pair-plane mode for reads |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 20 | Longword address in graphics memory |
| out_planes | output | 4 | Plane-select hint |
| out_mode | output | 2 | Mode applied: 0 planar, 1 pair-plane, 2 quad-plane |

## Verification
Every request result is due exactly one rising edge after the edge at which the request is presented. The base readback changes at the same edge that captures the write. The driver changes inputs on the falling edge and, at that moment, queues the outcome that the next rising edge must produce. The monitor pops one queued item one nanosecond after each rising edge, so each comparison falls in the single cycle its result belongs to. One case presents a base write and a request in the same cycle. That case confirms the old base is used, and that the readback already shows the new base in the same sampled cycle.

// File: rtl/vga_xlat_pkg.sv
package vga_xlat_pkg;

    localparam int XL_OFS_W     = 16;
    localparam int XL_ADDR_W    = 20;
    localparam int XL_BASE_W    = 6;
    localparam int XL_REG_W     = 32;
    localparam int XL_BASE_RDLO = 8;
    localparam int XL_PLANES    = 4;

    typedef enum logic [1:0] {
        XM_PLANAR = 2'd0,
        XM_PAIR   = 2'd1,
        XM_QUAD   = 2'd2
    } xlat_mode_e;

    typedef struct packed {
        logic quad;
        logic pack;
        logic odd_even;
        logic page_bit;
        logic force_top;
        logic pair_wr;
        logic pair_rd;
    } mode_ctl_t;

    // pick the pair-plane enable that matches the access direction
    function automatic logic pair_active(input mode_ctl_t c, input logic is_wr);
        return is_wr ? c.pair_wr : c.pair_rd;
    endfunction

endpackage

// File: rtl/vga_base_reg.sv
module vga_base_reg
    import vga_xlat_pkg::*;
#(
    parameter int REG_W   = XL_REG_W,
    parameter int BASE_W  = XL_BASE_W,
    parameter int RD_LO   = XL_BASE_RDLO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [BASE_W-1:0] base_q,
    output logic [REG_W-1:0]  rd_data
);
    localparam int RD_HI = RD_LO + BASE_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wr_data[BASE_W-1:0];
        end
    end

    always_comb begin
        rd_data              = '0;
        rd_data[RD_HI:RD_LO] = base_q;
    end
endmodule

// File: rtl/vga_offset_map.sv
module vga_offset_map
    import vga_xlat_pkg::*;
#(
    parameter int OFS_W  = XL_OFS_W,
    parameter int PLANES = XL_PLANES
) (
    input  logic [OFS_W-1:0]  cpu_ofs,
    input  logic              is_write,
    input  mode_ctl_t         ctl,
    output logic [OFS_W-1:0]  plane_ofs,
    output logic [PLANES-1:0] planes,
    output xlat_mode_e        mode
);
    localparam int SEL_W = $clog2(PLANES);
    localparam int TOP   = OFS_W - 1;

    logic [PLANES-1:0] quad_hot;
    logic [PLANES-1:0] pair_hot;

    for (genvar i = 0; i < PLANES; i++) begin : g_hint
        assign quad_hot[i] = (cpu_ofs[SEL_W-1:0] == SEL_W'(i));
        assign pair_hot[i] = (cpu_ofs[0] == ((i % 2) == 1));
    end

    always_comb begin
        plane_ofs = cpu_ofs;
        if (ctl.quad) begin
            if (ctl.pack) begin
                plane_ofs = cpu_ofs >> SEL_W;
            end else begin
                plane_ofs[SEL_W-1:0] = '0;
            end
        end else if (ctl.odd_even) begin
            plane_ofs[0] = ctl.page_bit;
        end
        if (ctl.force_top) begin
            plane_ofs[TOP] = 1'b0;
        end
    end

    always_comb begin
        if (ctl.quad) begin
            mode   = XM_QUAD;
            planes = quad_hot;
        end else if (pair_active(ctl, is_write)) begin
            mode   = XM_PAIR;
            planes = pair_hot;
        end else begin
            mode   = XM_PLANAR;
            planes = '1;
        end
    end
endmodule

// File: rtl/vga_addr_stage.sv
module vga_addr_stage
    import vga_xlat_pkg::*;
#(
    parameter int OFS_W  = XL_OFS_W,
    parameter int ADDR_W = XL_ADDR_W,
    parameter int BASE_W = XL_BASE_W,
    parameter int PLANES = XL_PLANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BASE_W-1:0] base,
    input  logic [OFS_W-1:0]  plane_ofs,
    input  logic [PLANES-1:0] planes,
    input  xlat_mode_e        mode,
    output logic              q_valid,
    output logic [ADDR_W-1:0] q_addr,
    output logic [PLANES-1:0] q_planes,
    output xlat_mode_e        q_mode
);
    localparam int BASE_LSB = ADDR_W - BASE_W;

    logic [ADDR_W-1:0] sum;

    assign sum = {base, {BASE_LSB{1'b0}}} + {{(ADDR_W-OFS_W){1'b0}}, plane_ofs};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid  <= 1'b0;
            q_addr   <= '0;
            q_planes <= '0;
            q_mode   <= XM_PLANAR;
        end else begin
            q_valid <= in_valid;
            if (in_valid) begin
                q_addr   <= sum;
                q_planes <= planes;
                q_mode   <= mode;
            end
        end
    end
endmodule

// File: rtl/vga_addr_xlat.sv
module vga_addr_xlat
    import vga_xlat_pkg::*;
#(
    parameter int OFS_W  = XL_OFS_W,
    parameter int ADDR_W = XL_ADDR_W,
    parameter int BASE_W = XL_BASE_W,
    parameter int REG_W  = XL_REG_W,
    parameter int RD_LO  = XL_BASE_RDLO,
    parameter int PLANES = XL_PLANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              mode_chain4,
    input  logic              mode_packed,
    input  logic              mode_odd_even,
    input  logic              mode_page_bit,
    input  logic              mode_force_a15,
    input  logic              mode_wr_chain2,
    input  logic              mode_rd_chain2,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [PLANES-1:0] out_planes,
    output logic [1:0]        out_mode
);
    mode_ctl_t         ctl;
    logic [BASE_W-1:0] base_q;
    logic [OFS_W-1:0]  plane_ofs;
    logic [PLANES-1:0] planes;
    xlat_mode_e        mode_c;
    xlat_mode_e        mode_q;

    assign ctl = '{quad:      mode_chain4,
                   pack:      mode_packed,
                   odd_even:  mode_odd_even,
                   page_bit:  mode_page_bit,
                   force_top: mode_force_a15,
                   pair_wr:   mode_wr_chain2,
                   pair_rd:   mode_rd_chain2};

    vga_base_reg #(.REG_W(REG_W), .BASE_W(BASE_W), .RD_LO(RD_LO)) u_base (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .base_q  (base_q),
        .rd_data (cfg_rd_data)
    );

    vga_offset_map #(.OFS_W(OFS_W), .PLANES(PLANES)) u_map (
        .cpu_ofs   (req_offset),
        .is_write  (req_write),
        .ctl       (ctl),
        .plane_ofs (plane_ofs),
        .planes    (planes),
        .mode      (mode_c)
    );

    vga_addr_stage #(.OFS_W(OFS_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W), .PLANES(PLANES)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .base      (base_q),
        .plane_ofs (plane_ofs),
        .planes    (planes),
        .mode      (mode_c),
        .q_valid   (out_valid),
        .q_addr    (out_addr),
        .q_planes  (out_planes),
        .q_mode    (mode_q)
    );

    assign out_mode = mode_q;
endmodule

// File: rtl/vga_addr_xlat_chk.sv
module vga_addr_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr_en,
    input logic [31:0] cfg_wr_data,
    input logic [31:0] cfg_rd_data,
    input logic        req_valid,
    input logic        mode_chain4,
    input logic        mode_force_a15,
    input logic        out_valid,
    input logic [19:0] out_addr,
    input logic [3:0]  out_planes,
    input logic [1:0]  out_mode
);
    logic [19:0] ofs_seen;
    assign ofs_seen = out_addr - {cfg_rd_data[13:8], 14'b0};

    // R1
    base_write_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_en |=> cfg_rd_data[13:8] == $past(cfg_wr_data[5:0]));

    // R1
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> $stable(cfg_rd_data));

    // R1
    rd_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_data[31:14] == '0 && cfg_rd_data[7:0] == '0);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    // R5
    quad_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == 2'd2) |-> $countones(out_planes) == 1);

    // R9
    pair_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == 2'd1) |-> (out_planes == 4'b0101 || out_planes == 4'b1010));

    // R9
    quad_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_chain4) |=> out_mode == 2'd2);

    // R10
    top_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_force_a15 && !cfg_wr_en) |=> ofs_seen[15] == 1'b0);
endmodule

bind vga_addr_xlat vga_addr_xlat_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_data    (cfg_wr_data),
    .cfg_rd_data    (cfg_rd_data),
    .req_valid      (req_valid),
    .mode_chain4    (mode_chain4),
    .mode_force_a15 (mode_force_a15),
    .out_valid      (out_valid),
    .out_addr       (out_addr),
    .out_planes     (out_planes),
    .out_mode       (out_mode)
);

// File: tb/vga_addr_xlat_bench.sv
module vga_addr_xlat_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_offset = '0;
    logic        mode_chain4 = 1'b0, mode_packed = 1'b0, mode_odd_even = 1'b0;
    logic        mode_page_bit = 1'b0, mode_force_a15 = 1'b0;
    logic        mode_wr_chain2 = 1'b0, mode_rd_chain2 = 1'b0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [3:0]  out_planes;
    logic [1:0]  out_mode;

    always #2 clk = ~clk;

    vga_addr_xlat u_vga_addr_xlat (.*);

    // control bit order: {quad, pack, odd_even, page, force15, pair_wr, pair_rd}
    localparam logic [6:0] C4 = 7'b1000000, PK = 7'b0100000, OE = 7'b0010000,
                           PB = 7'b0001000, F15 = 7'b0000100, W2 = 7'b0000010,
                           R2 = 7'b0000001, NONE = 7'b0;

    typedef struct {
        logic        v;
        logic [19:0] a;
        logic [3:0]  p;
        logic [1:0]  m;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic [5:0] base_m = '0;
    bit   done = 0;

    task automatic drive(input logic we, input logic [31:0] wd, input logic rv,
                         input logic rw, input logic [15:0] ofs,
                         input logic [6:0] c, input string tag);
        exp_t e;
        logic [15:0] po;
        logic pair;
        @(negedge clk);
        cfg_wr_en = we; cfg_wr_data = wd; req_valid = rv; req_write = rw;
        req_offset = ofs;
        {mode_chain4, mode_packed, mode_odd_even, mode_page_bit,
         mode_force_a15, mode_wr_chain2, mode_rd_chain2} = c;
        // expected result from the requirements, using the old base (R1)
        po = ofs;
        if (c[6]) po = c[5] ? (ofs >> 2) : {ofs[15:2], 2'b00};
        else if (c[4]) po[0] = c[3];
        if (c[2]) po[15] = 1'b0;
        pair = rw ? c[1] : c[0];
        e.v = rv;
        e.a = {base_m, 14'b0} + {4'b0, po};
        if (c[6]) begin e.m = 2'd2; e.p = 4'b0001 << ofs[1:0]; end
        else if (pair) begin e.m = 2'd1; e.p = ofs[0] ? 4'b1010 : 4'b0101; end
        else begin e.m = 2'd0; e.p = 4'b1111; end
        if (we) base_m = wd[5:0];
        e.rd = {18'b0, base_m, 8'b0};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic req(input logic rw, input logic [15:0] ofs,
                       input logic [6:0] c, input string tag);
        drive(1'b0, 32'h0, 1'b1, rw, ofs, c, tag);
    endtask

    // monitor: one item per rising edge, sampled 1 ns after it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (out_valid !== e.v || cfg_rd_data !== e.rd ||
                    (e.v && (out_addr !== e.a || out_planes !== e.p || out_mode !== e.m))) begin
                    errors++;
                    $display("FAIL %s: got v=%b addr=%h planes=%b mode=%0d rd=%h exp v=%b addr=%h planes=%b mode=%0d rd=%h",
                             e.tag, out_valid, out_addr, out_planes, out_mode, cfg_rd_data,
                             e.v, e.a, e.p, e.m, e.rd);
                end
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || cfg_rd_data !== 32'h0) begin
            errors++;
            $display("FAIL R1/R2 reset: got v=%b rd=%h exp v=0 rd=00000000", out_valid, cfg_rd_data);
        end
        @(negedge clk);
        rst = 1'b0;

        drive(1'b1, 32'hFFFF_FFC5, 1'b0, 1'b0, 16'h0, NONE, "R1 base write, reserved ignored");
        drive(1'b1, 32'h0000_3F00, 1'b0, 1'b0, 16'h0, NONE, "R1 high bits ignored");
        drive(1'b1, 32'h0000_0005, 1'b0, 1'b0, 16'h0, NONE, "R1 base 5");
        req(1'b0, 16'h1234, NONE,      "R4 planar read");
        req(1'b1, 16'hFFFF, NONE,      "R4 R3 planar write");
        drive(1'b0, 32'h0, 1'b0, 1'b0, 16'h1234, NONE, "R2 idle");
        req(1'b1, 16'h1237, C4,        "R5 quad write");
        req(1'b0, 16'h1237, C4,        "R11 quad read");
        for (int i = 0; i < 4; i++) req(1'b1, 16'h4440 + 16'(i), C4, "R5 quad plane sweep");
        req(1'b1, 16'h1237, C4 | PK,   "R6 packed quad");
        req(1'b0, 16'hFFFF, C4 | PK,   "R6 R11 packed quad read");
        req(1'b0, 16'h1237, PK,        "R7 pack without quad");
        req(1'b1, 16'h1236, PK | OE | PB, "R7 R8 pack with odd/even");
        req(1'b0, 16'h2000, OE | PB,   "R8 page bit 1");
        req(1'b0, 16'h2001, OE,        "R8 page bit 0");
        req(1'b1, 16'h2001, OE | W2,   "R9 pair write odd");
        req(1'b1, 16'h2000, W2,        "R9 pair write even");
        req(1'b0, 16'h2001, W2,        "R9 read ignores write pair");
        req(1'b0, 16'h3002, R2,        "R9 pair read");
        req(1'b1, 16'h3003, C4 | W2 | R2, "R9 quad precedence");
        req(1'b0, 16'h9234, F15,       "R10 force top bit");
        req(1'b0, 16'h8000, F15 | OE | PB, "R10 after page bit");
        req(1'b1, 16'hFFFF, F15 | C4 | PK, "R10 after packing");
        drive(1'b1, 32'h0000_003F, 1'b1, 1'b0, 16'hC000, NONE, "R1 same-cycle write uses old base");
        req(1'b0, 16'hC000, NONE,      "R3 wrap with base 63");
        req(1'b1, 16'hFFFF, C4,        "R3 wrap quad base 63");
        drive(1'b0, 32'h0, 1'b0, 1'b0, 16'h0, NONE, "R2 final idle");

        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule